// File: doc/BRIEF.md
# Multiplexed Host Bus Register Port

This block is the slave side of a shared address/data bus through which an external host programs a modem datapath. The host first drives a word address on the 16 shared bus lines while pulsing an address strobe. It then drives or reads a full 16-bit data word under a write or read strobe. The host runs with no clock of its own that is visible to the block. Every strobe is therefore brought into the core clock by a synchronizer chain, and each strobe edge becomes a one-cycle internal pulse.

There are no byte accesses, so the lowest bus address bit carries no meaning. The word-select bit arrives on its own dedicated pin rather than on the shared bus. A control bit selects the byte order seen on the bus, and big endian is the order after reset. A small demonstrator register set sits behind the port: the control register, an event status register with write-one-to-clear bits, an event mask, and a bank of coefficient words that drive the datapath. An interrupt request is pulled low while any unmasked status bit is set. It is released to high impedance otherwise.

Top module: `hbp_port`

## Requirements
- R1: After reset the port is big endian, the status, mask and coefficient registers read 0x0000, the bus is not driven, and the interrupt is released.
- R2: On the falling edge of `ale_i` the word index is taken as {`ad_i`[15:2], `sel_i`}. Bus bits 1 and 0 are ignored during the address phase.
- R3: At the rising (release) edge of `wr_n_i`, the word on `ad_i` is stored into the addressed register. A coefficient register reads back exactly the stored 16-bit value.
- R4: Once `rd_n_i` has been low for at least five clocks, `ad_oe_o` is high and `ad_o` carries the addressed register. Within five clocks after `rd_n_i` returns high, `ad_oe_o` is low.
- R5: Word index 0 is the control register, and its bit 0 set to 1 selects little endian. In that mode the two bytes of write data and of read data are swapped. A write to the control register is decoded under the byte order in force before that write.
- R6: Word index 1 holds one status bit per event input, and a one-cycle event pulse sets its bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R7: Word index 2 is the mask, where bit i set enables status bit i. `irq_n_o` is driven low, and `irq_drive_o` is high, exactly while some status bit and its mask bit are both set. Both follow an event by one clock.
- R8: Coefficient registers occupy word indices 4 and up. A read of any other index (3, or 4+NCOEF and above) returns 0x0000, and a write to such an index changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous-free reset, sampled on clk |
| ad_i | input | 16 | Shared bus, value seen by the port (address or write data) |
| ad_o | output | 16 | Read data driven onto the shared bus |
| ad_oe_o | output | 1 | Bus output enable for read data |
| ale_i | input | 1 | Address strobe, active high, address taken at its fall |
| sel_i | input | 1 | Dedicated word-select pin (address bit 1) |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low, data stored at its release |
| evt_i | input | NEVT | One-cycle event pulses from the datapath |
| coef_o | output | NCOEF*16 | Coefficient register contents, word 0 in the low bits |
| irq_drive_o | output | 1 | High while the interrupt line is being pulled low |
| irq_n_o | output | 1 | Open-drain interrupt request: 0 when asserted, high impedance otherwise |

## Verification
An event pulse and a write-one-to-clear of the status register can land in the same core cycle. The outcome must be that the bit stays set. The bench provokes this by counting the synchronizer stages after it releases the write strobe, and it drives the event pulse exactly in the cycle in which the write takes effect. It then judges the result by reading the status word back and by watching the interrupt output, with the matching mask bit enabled.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam int DW   = 16;
    localparam int WIDX = 15;

    localparam logic [WIDX-1:0] W_CTRL  = 15'd0;
    localparam logic [WIDX-1:0] W_STAT  = 15'd1;
    localparam logic [WIDX-1:0] W_MASK  = 15'd2;
    localparam logic [WIDX-1:0] W_COEF0 = 15'd4;

    typedef struct packed {
        logic [WIDX-1:0] widx;
        logic [DW-1:0]   rdata;
        logic            oe;
    } port_st_t;

    function automatic logic [DW-1:0] swap16(input logic [DW-1:0] v, input logic en);
        return en ? {v[7:0], v[15:8]} : v;
    endfunction

endpackage

// File: rtl/hbp_sync_edge.sv
module hbp_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = STAGES + 1;

    logic [CW-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CW-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {CW{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];

    // one access per strobe edge: a pulse never lasts two cycles (R3)
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o | fall_o) |=> !(rise_o | fall_o));

endmodule

// File: rtl/hbp_regs.sv
module hbp_regs
    import hbp_pkg::*;
#(
    parameter int NEVT  = 8,
    parameter int NCOEF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WIDX-1:0]   widx_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NEVT-1:0]   evt_i,
    output logic [DW-1:0]     rdata_o,
    output logic              hit_o,
    output logic              le_o,
    output logic [NCOEF*DW-1:0] coef_o,
    output logic              irq_o
);
    typedef struct packed {
        logic                      le;
        logic [NEVT-1:0]           stat;
        logic [NEVT-1:0]           mask;
        logic [NCOEF-1:0][DW-1:0]  coef;
    } regs_t;

    regs_t           r_d, r_q;
    logic [NCOEF-1:0] coef_hit;
    logic [NEVT-1:0]  clr;
    logic             ctrl_hit, stat_hit, mask_hit;

    for (genvar g = 0; g < NCOEF; g++) begin : g_coef
        assign coef_hit[g]              = (widx_i == W_COEF0 + WIDX'(g));
        assign coef_o[g*DW +: DW]       = r_q.coef[g];
    end

    assign ctrl_hit = (widx_i == W_CTRL);
    assign stat_hit = (widx_i == W_STAT);
    assign mask_hit = (widx_i == W_MASK);

    always_comb begin
        hit_o   = ctrl_hit | stat_hit | mask_hit | (|coef_hit);
        rdata_o = '0;
        if (ctrl_hit) rdata_o = {{(DW-1){1'b0}}, r_q.le};
        if (stat_hit) rdata_o = DW'(r_q.stat);
        if (mask_hit) rdata_o = DW'(r_q.mask);
        for (int i = 0; i < NCOEF; i++) begin
            if (coef_hit[i]) rdata_o = r_q.coef[i];
        end
    end

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (wr_i) begin
            if (ctrl_hit) r_d.le   = wdata_i[0];
            if (stat_hit) clr      = wdata_i[NEVT-1:0];
            if (mask_hit) r_d.mask = wdata_i[NEVT-1:0];
            for (int i = 0; i < NCOEF; i++) begin
                if (coef_hit[i]) r_d.coef[i] = wdata_i;
            end
        end
        r_d.stat = (r_q.stat & ~clr) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign le_o  = r_q.le;
    assign irq_o = |(r_q.stat & r_q.mask);

    assert_evt_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((r_q.stat & $past(evt_i)) == $past(evt_i)));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && stat_hit) |=> ((r_q.stat & $past(wdata_i[NEVT-1:0] & ~evt_i)) == '0));

    assert_irq_after_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_i & r_q.mask)) && !(wr_i && mask_hit)) |=> irq_o);

    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !hit_o) |=> ($stable(r_q.le) && $stable(r_q.mask) && $stable(r_q.coef)));

endmodule

// File: rtl/hbp_port.sv
module hbp_port
    import hbp_pkg::*;
#(
    parameter int NEVT        = 8,
    parameter int NCOEF       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          ad_i,
    output logic [15:0]          ad_o,
    output logic                 ad_oe_o,
    input  logic                 ale_i,
    input  logic                 sel_i,
    input  logic                 rd_n_i,
    input  logic                 wr_n_i,
    input  logic [NEVT-1:0]      evt_i,
    output logic [NCOEF*16-1:0]  coef_o,
    output logic                 irq_drive_o,
    output logic                 irq_n_o
);
    localparam int         NSTB     = 3;
    localparam logic [2:0] STB_IDLE = 3'b110;   // wr_n, rd_n idle high; ale idle low

    logic [NSTB-1:0] stb_raw, stb_lvl, stb_rise, stb_fall;
    assign stb_raw = {wr_n_i, rd_n_i, ale_i};

    for (genvar g = 0; g < NSTB; g++) begin : g_sync
        hbp_sync_edge #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (STB_IDLE[g])
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (stb_raw[g]),
            .level_o (stb_lvl[g]),
            .rise_o  (stb_rise[g]),
            .fall_o  (stb_fall[g])
        );
    end

    logic ale_pulse, rd_pulse, wr_pulse, rd_active;
    assign ale_pulse = stb_fall[0];
    assign rd_pulse  = stb_fall[1];
    assign rd_active = ~stb_lvl[1];
    assign wr_pulse  = stb_rise[2];

    port_st_t st_d, st_q;

    logic [DW-1:0] reg_rdata, wdata_native;
    logic          reg_hit, le, irq_pull;
    logic          unused_addr_lsbs;
    assign unused_addr_lsbs = ^ad_i[1:0] ^ stb_rise[0] ^ stb_rise[1] ^ stb_fall[2] ^ stb_lvl[0] ^ stb_lvl[2];

    assign wdata_native = swap16(ad_i, le);

    hbp_regs #(
        .NEVT  (NEVT),
        .NCOEF (NCOEF)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_pulse),
        .widx_i  (st_q.widx),
        .wdata_i (wdata_native),
        .evt_i   (evt_i),
        .rdata_o (reg_rdata),
        .hit_o   (reg_hit),
        .le_o    (le),
        .coef_o  (coef_o),
        .irq_o   (irq_pull)
    );

    always_comb begin
        st_d = st_q;
        if (ale_pulse) st_d.widx  = {ad_i[15:2], sel_i};
        if (rd_pulse)  st_d.rdata = swap16(reg_rdata, le);
        st_d.oe = rd_active & (rd_pulse | st_q.oe);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ad_o        = st_q.rdata;
    assign ad_oe_o     = st_q.oe;
    assign irq_drive_o = irq_pull;
    assign irq_n_o     = irq_pull ? 1'b0 : 1'bz;

    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && !reg_hit) |=> (ad_o == 16'h0000));

    assert_bus_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |=> !ad_oe_o);

    assert_drive_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> ad_oe_o);

endmodule

// File: tb/hbp_port_tb.sv
module hbp_port_tb_top;
    localparam int NEVT  = 8;
    localparam int NCOEF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] ad_i = '0;
    logic [15:0] ad_o;
    logic ad_oe;
    logic ale = 1'b0, sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [NEVT-1:0] evt = '0;
    logic [NCOEF*16-1:0] coef;
    logic irq_drive;
    wire  irq_n;

    always #2 clk = ~clk;   // 250 MHz

    hbp_port #(.NEVT(NEVT), .NCOEF(NCOEF)) dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe),
        .ale_i(ale), .sel_i(sel), .rd_n_i(rd_n), .wr_n_i(wr_n), .evt_i(evt),
        .coef_o(coef), .irq_drive_o(irq_drive), .irq_n_o(irq_n)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic             m_le = 1'b0;
    logic [NEVT-1:0]  m_stat = '0, m_mask = '0;
    logic [15:0]      m_coef [NCOEF];

    function automatic logic [15:0] swp(logic [15:0] v, logic en);
        return en ? {v[7:0], v[15:8]} : v;
    endfunction

    function automatic logic [15:0] model_read(int w);
        logic [15:0] v = '0;
        if (w == 0) v = {15'd0, m_le};
        else if (w == 1) v = 16'(m_stat);
        else if (w == 2) v = 16'(m_mask);
        else if (w >= 4 && w < 4 + NCOEF) v = m_coef[w-4];
        return swp(v, m_le);
    endfunction

    task automatic model_write(int w, logic [15:0] d, logic [NEVT-1:0] e);
        logic [15:0] n = swp(d, m_le);
        logic [NEVT-1:0] clr = '0;
        if (w == 0) m_le = n[0];
        else if (w == 1) clr = n[NEVT-1:0];
        else if (w == 2) m_mask = n[NEVT-1:0];
        else if (w >= 4 && w < 4 + NCOEF) m_coef[w-4] = n;
        m_stat = (m_stat & ~clr) | e;
    endtask

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic addr_phase(int w, logic [1:0] junk);
        @(posedge clk); #1;
        ad_i = {w[14:1], junk} ; sel = w[0]; ale = 1'b1;
        repeat (3) @(posedge clk); #1 ale = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic bus_write(int w, logic [15:0] d, logic [NEVT-1:0] e, logic [1:0] junk);
        addr_phase(w, junk);
        #1 ad_i = d; wr_n = 1'b0;
        repeat (3) @(posedge clk); #1 wr_n = 1'b1;
        repeat (2) @(posedge clk); #1 evt = e;
        @(posedge clk); #1 evt = '0;
        repeat (3) @(posedge clk);
        model_write(w, d, e);
    endtask

    task automatic bus_read(int w, logic [1:0] junk, output logic [15:0] v,
                            output logic oe_on, output logic oe_off);
        addr_phase(w, junk);
        #1 ad_i = 16'h0; rd_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk); v = ad_o; oe_on = ad_oe;
        @(posedge clk); #1 rd_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk); oe_off = ad_oe;
    endtask

    task automatic read_check(int w, string req);
        logic [15:0] v; logic on, off;
        bus_read(w, 2'($urandom_range(0, 3)), v, on, off);
        check(v == model_read(w), req, v, model_read(w));
        check(on && !off, "R4 output enable", {14'd0, on, off}, 16'h0002);
    endtask

    task automatic irq_check(string req);
        logic exp = |(m_stat & m_mask);
        @(negedge clk);
        check(irq_drive == exp, req, 16'(irq_drive), 16'(exp));
        if (exp) check(irq_n == 1'b0, req, 16'(irq_n), 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < NCOEF; i++) m_coef[i] = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ad_oe == 1'b0, "R1 bus idle", 16'(ad_oe), 16'h0);
        check(irq_drive == 1'b0, "R1 irq released", 16'(irq_drive), 16'h0);
        check(coef == '0, "R1 coef zero", coef[15:0], 16'h0);
        for (int w = 0; w < 8; w++) read_check(w, "R1 reset read");

        // R5 big endian default, R3 write/readback
        bus_write(4, 16'h1234, '0, 2'b00);
        read_check(4, "R5 big endian default");
        check(coef[15:0] == 16'h1234, "R3 coef output", coef[15:0], 16'h1234);
        // R2 bus address bits 1:0 ignored, bit 1 taken from pin
        bus_write(5, 16'h5A5A, '0, 2'b11);
        read_check(5, "R2 address lsbs ignored");
        check(coef[31:16] == 16'h5A5A, "R2 word select pin", coef[31:16], 16'h5A5A);
        // R5 switch to little endian
        bus_write(0, 16'h0001, '0, 2'b00);
        read_check(0, "R5 control reads swapped");
        read_check(4, "R5 little endian read");
        bus_write(6, 16'hABCD, '0, 2'b00);
        check(coef[47:32] == 16'hCDAB, "R5 little endian write", coef[47:32], 16'hCDAB);
        bus_write(0, 16'h0000, '0, 2'b00);
        read_check(6, "R5 back to big endian");

        // R8 unmapped
        bus_write(3, 16'hFFFF, '0, 2'b00);
        bus_write(8, 16'hFFFF, '0, 2'b00);
        bus_write(16'h2000, 16'hFFFF, '0, 2'b00);
        read_check(3, "R8 unmapped read");
        read_check(16'h2000, "R8 unmapped high read");
        for (int w = 0; w < 8; w++) read_check(w, "R8 no register changed");

        // R6/R7 events, mask, clear
        @(posedge clk); #1 evt = 8'h05;
        @(posedge clk); #1 evt = '0;
        m_stat |= 8'h05;
        irq_check("R7 masked event no irq");
        bus_write(2, 16'h0004, '0, 2'b00);
        irq_check("R7 unmask raises irq");
        read_check(1, "R6 status bits set");
        bus_write(1, 16'h0004, '0, 2'b00);
        irq_check("R7 clear releases irq");
        read_check(1, "R6 write one clears only that bit");
        // R6 same-cycle event and clear: set wins
        bus_write(2, 16'h0001, '0, 2'b00);
        bus_write(1, 16'h0001, 8'h01, 2'b00);
        read_check(1, "R6 set wins over clear");
        irq_check("R6 irq held through clear");
        bus_write(1, 16'h00FF, '0, 2'b00);
        irq_check("R7 irq released after clear");

        // random mix
        for (int k = 0; k < 300; k++) begin
            int w = $urandom_range(0, 9);
            logic [1:0] j = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 2))
                0: bus_write(w, 16'($urandom), '0, j);
                1: read_check(w, "R3 random read");
                default: begin
                    logic [NEVT-1:0] e = NEVT'($urandom);
                    @(posedge clk); #1 evt = e;
                    @(posedge clk); #1 evt = '0;
                    m_stat |= e;
                end
            endcase
            irq_check("R7 random irq");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule